// File: doc/BRIEF.md
# Double-Buffered UART Receiver with Error Flags

This block recovers asynchronous serial characters from a single input line. The line is sampled on a 16x oversampling enable, `tick16`, which an external divider supplies. A falling edge starts a character, and the start bit must still be low at its middle sample to be accepted. Each following bit is sampled once, at the centre of its bit period. The frame carries 7 or 8 data bits with the least significant bit first, an optional parity bit of even or odd sense, and one or two stop bits.

When the first stop bit has been sampled, the character moves into a holding buffer and the buffer-full flag rises. The parity, framing and overrun flags are updated in that same cycle. The buffer keeps the character while the next one is shifted in, so software has a whole character time to read it. A one-cycle interrupt pulse marks each rise of the buffer-full flag.

The control FSM has six states. In IDLE it waits for a low sample and then goes to START. START samples the middle of the start bit; a high sample there returns it to IDLE, and a low sample moves it to DATA. DATA collects the data bits. After the last data bit it goes to PARITY if parity is enabled, and to STOP1 if not. PARITY samples the parity bit and goes to STOP1. STOP1 samples the first stop bit and delivers the character. From STOP1 the FSM goes to STOP2 in two-stop mode and to IDLE otherwise. STOP2 waits out the second stop bit and then returns to IDLE.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset `rbf`, `rx_irq`, `ovr_err`, `par_err` and `frm_err` are 0 and `rx_data` is 0.
- R2: Bits are received least significant first. `cfg_len8`=1 selects 8 data bits. `cfg_len8`=0 selects 7 data bits, and `rx_data[7]` then reads 0. `cfg_par_en`=1 adds a parity bit after the data. `cfg_stop2`=1 selects two stop bits.
- R3: The start bit is accepted only if `rxd` is still 0 at the 8th tick after the tick that first saw it low. Otherwise the receiver returns to idle, and no character or interrupt is produced.
- R4: The character is written to `rx_data` and `rbf` sets at the first stop-bit sample. This happens before the second stop bit in two-stop mode.
- R5: A one-cycle `rd_en` pulse clears `rbf`, unless a character completes in the same cycle.
- R6: `rx_irq` is a one-cycle pulse issued exactly when `rbf` changes from 0 to 1.
- R7: With parity enabled, `par_err` sets when the data bits and the parity bit together hold an odd count of ones with `cfg_par_odd`=0, or an even count with `cfg_par_odd`=1.
- R8: `frm_err` sets when the first stop bit samples as 0.
- R9: If a character completes while `rbf` is 1 and no read occurs in that cycle, `ovr_err` sets. `rx_data` keeps the old character, and no interrupt is issued.
- R10: The error flags stay set until `err_clr` is pulsed. A new error arriving in the same cycle as `err_clr` wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len8 | input | 1 | 1 for 8 data bits, 0 for 7 |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cfg_stop2 | input | 1 | 1 for two stop bits |
| rd_en | input | 1 | Buffer read strobe, clears rbf |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 8 | Receive buffer contents |
| rbf | output | 1 | Receive buffer full |
| ovr_err | output | 1 | Overrun error, sticky |
| par_err | output | 1 | Parity error, sticky |
| frm_err | output | 1 | Framing error, sticky |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default parameters: 16 ticks per bit and an 8-bit data path. This lets both character lengths be exercised, including the forced-zero top bit in 7-bit mode. The tick arrives every fourth clock. A bit period is therefore 64 clocks, which leaves room to sample the flags after the first stop bit and before a second stop bit ends. It also makes a short false start easy to build.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;
endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    output logic          chr_done,
    output logic [DW-1:0] chr_data,
    output logic          chr_par_bad,
    output logic          chr_frm_bad
);
    localparam int CW  = $clog2(OVS);
    localparam int IW  = $clog2(DW);
    localparam int MID = OVS / 2;

    rx_state_t     state, state_n;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] shreg;
    logic          pbit;
    logic          half_pt, samp_pt;
    logic [IW-1:0] last_idx;

    assign half_pt  = tick16 && (cnt == CW'(MID - 1));
    assign samp_pt  = tick16 && (cnt == CW'(OVS - 1));
    assign last_idx = cfg_len8 ? IW'(DW - 1) : IW'(DW - 2);

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:   if (tick16 && !rxd) state_n = RX_START;
            RX_START:  if (half_pt) state_n = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:   if (samp_pt && idx == last_idx)
                           state_n = cfg_par_en ? RX_PARITY : RX_STOP1;
            RX_PARITY: if (samp_pt) state_n = RX_STOP1;
            RX_STOP1:  if (samp_pt) state_n = cfg_stop2 ? RX_STOP2 : RX_IDLE;
            RX_STOP2:  if (samp_pt) state_n = RX_IDLE;
            default:   state_n = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else begin
            if (tick16)
                cnt <= (state_n != state || samp_pt) ? '0 : cnt + 1'b1;
            if (state == RX_START) begin
                idx   <= '0;
                shreg <= '0;
            end
            if (state == RX_DATA && samp_pt) begin
                shreg[idx] <= rxd;
                idx        <= idx + 1'b1;
            end
            if (state == RX_PARITY && samp_pt)
                pbit <= rxd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chr_done    <= 1'b0;
            chr_par_bad <= 1'b0;
            chr_frm_bad <= 1'b0;
        end else begin
            chr_done <= 1'b0;
            if (state == RX_STOP1 && samp_pt) begin
                chr_done    <= 1'b1;
                chr_frm_bad <= !rxd;
                chr_par_bad <= cfg_par_en && ((^shreg ^ pbit) != cfg_par_odd);
            end
        end
    end

    assign chr_data = shreg;

    // R3
    property false_start_idle_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (state == RX_START && half_pt && rxd) |=> (state == RX_IDLE);
    endproperty
    false_start_idle_chk: assert property (false_start_idle_chk_p);

    // R2
    property bit_index_range_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (state == RX_DATA) |-> (idx <= last_idx);
    endproperty
    bit_index_range_chk: assert property (bit_index_range_chk_p);

    // R4
    property done_from_stop1_chk_p;
        @(posedge clk) disable iff (!rst_n)
            chr_done |-> ($past(state) == RX_STOP1);
    endproperty
    done_from_stop1_chk: assert property (done_from_stop1_chk_p);
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_done,
    input  logic [DW-1:0] chr_data,
    input  logic          chr_par_bad,
    input  logic          chr_frm_bad,
    input  logic          rd_en,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rbf,
    output logic          ovr_err,
    output logic          par_err,
    output logic          frm_err,
    output logic          rx_irq
);
    logic ovr_now;

    assign ovr_now = chr_done && rbf && !rd_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rbf     <= 1'b0;
            rx_irq  <= 1'b0;
            ovr_err <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            rx_irq <= chr_done && !rbf;
            if (chr_done && !ovr_now)
                rx_data <= chr_data;
            if (chr_done)
                rbf <= 1'b1;
            else if (rd_en)
                rbf <= 1'b0;
            ovr_err <= (ovr_err && !err_clr) || ovr_now;
            par_err <= (par_err && !err_clr) || (chr_done && chr_par_bad);
            frm_err <= (frm_err && !err_clr) || (chr_done && chr_frm_bad);
        end
    end

    // R6
    property irq_on_rise_chk_p;
        @(posedge clk) disable iff (!rst_n)
            rx_irq |-> (rbf && !$past(rbf));
    endproperty
    irq_on_rise_chk: assert property (irq_on_rise_chk_p);

    // R5
    property read_clears_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (rd_en && !chr_done) |=> !rbf;
    endproperty
    read_clears_chk: assert property (read_clears_chk_p);

    // R9
    property overrun_keep_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (chr_done && rbf && !rd_en) |=> (ovr_err && $stable(rx_data) && !rx_irq);
    endproperty
    overrun_keep_chk: assert property (overrun_keep_chk_p);

    // R10
    property ovr_sticky_chk_p;
        @(posedge clk) disable iff (!rst_n)
            (ovr_err && !err_clr) |=> ovr_err;
    endproperty
    ovr_sticky_chk: assert property (ovr_sticky_chk_p);
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          rd_en,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rbf,
    output logic          ovr_err,
    output logic          par_err,
    output logic          frm_err,
    output logic          rx_irq
);
    logic          chr_done;
    logic [DW-1:0] chr_data;
    logic          chr_par_bad;
    logic          chr_frm_bad;

    uart_rx_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .rxd         (rxd),
        .cfg_len8    (cfg_len8),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .chr_done    (chr_done),
        .chr_data    (chr_data),
        .chr_par_bad (chr_par_bad),
        .chr_frm_bad (chr_frm_bad)
    );

    uart_rx_buf #(.DW(DW)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .chr_done    (chr_done),
        .chr_data    (chr_data),
        .chr_par_bad (chr_par_bad),
        .chr_frm_bad (chr_frm_bad),
        .rd_en       (rd_en),
        .err_clr     (err_clr),
        .rx_data     (rx_data),
        .rbf         (rbf),
        .ovr_err     (ovr_err),
        .par_err     (par_err),
        .frm_err     (frm_err),
        .rx_irq      (rx_irq)
    );
endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       len8;
        logic       pen;
        logic       podd;
        logic       stop2;
        logic       bad_par;
        logic       bad_stop;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       rd_en = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rbf, ovr_err, par_err, frm_err, rx_irq;
    logic [1:0] tdiv = '0;
    int         checks = 0, errors = 0, irq_cnt = 0;

    uart_rx_dbuf dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_en(rd_en), .err_clr(err_clr),
        .rx_data(rx_data), .rbf(rbf), .ovr_err(ovr_err), .par_err(par_err),
        .frm_err(frm_err), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick16);
        end
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    endtask

    // Drives a frame up to 12 ticks into the first stop bit.
    task automatic send_head(input vec_t v);
        int         nb;
        logic [7:0] d;
        logic       p;
        nb = v.len8 ? 8 : 7;
        d  = v.len8 ? v.data : {1'b0, v.data[6:0]};
        p  = (^d) ^ v.podd ^ v.bad_par;
        cfg_len8 = v.len8; cfg_par_en = v.pen; cfg_par_odd = v.podd; cfg_stop2 = v.stop2;
        ticks(1);
        rxd = 1'b0; ticks(16);
        for (int b = 0; b < nb; b++) begin rxd = d[b]; ticks(16); end
        if (v.pen) begin rxd = p; ticks(16); end
        rxd = !v.bad_stop; ticks(12);
    endtask

    task automatic send_tail(input vec_t v);
        rxd = 1'b1; ticks(4);
        if (v.stop2) ticks(16);
        ticks(20);
    endtask

    task automatic send(input vec_t v);
        send_head(v); send_tail(v);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int   irq0;
        vec_t v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rbf", rbf, 0);
        check("R1 flags", {ovr_err, par_err, frm_err}, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 data", rx_data, 0);
        rst_n = 1'b1;
        ticks(4);

        foreach (VECS[k]) begin
            v = VECS[k];
            pulse_clr();
            irq0 = irq_cnt;
            send_head(v);
            // R4 buffer loaded at first stop sample, before any second stop bit
            check("R4 rbf", rbf, 1);
            // R2 data bits, 7-bit mode clears the top bit
            check("R2 data", rx_data, v.len8 ? v.data : {1'b0, v.data[6:0]});
            // R7 parity
            check("R7 par_err", par_err, v.pen & v.bad_par);
            // R8 framing
            check("R8 frm_err", frm_err, v.bad_stop);
            check("R9 no ovr", ovr_err, 0);
            // R6 one pulse
            check("R6 irq", irq_cnt - irq0, 1);
            send_tail(v);
            pulse_rd();
            // R5 read clears
            check("R5 rbf clear", rbf, 0);
        end

        // R3 false start: low for 5 ticks only
        pulse_clr();
        irq0 = irq_cnt;
        cfg_len8 = 1'b1; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        rxd = 1'b0; ticks(5); rxd = 1'b1; ticks(40);
        check("R3 no char", rbf, 0);
        check("R3 no irq", irq_cnt - irq0, 0);
        v = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6B};
        send(v);
        check("R3 next char", rx_data, 8'h6B);
        pulse_rd();

        // R9 overrun keeps old data, no second interrupt
        irq0 = irq_cnt;
        v.data = 8'h11; send(v);
        v.data = 8'h22; send(v);
        check("R9 ovr_err", ovr_err, 1);
        check("R9 data kept", rx_data, 8'h11);
        check("R9 one irq", irq_cnt - irq0, 1);
        pulse_rd();

        // R10 sticky flags
        v = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h99};
        send(v); pulse_rd();
        v.bad_par = 1'b0;
        send(v); pulse_rd();
        check("R10 par sticky", par_err, 1);
        check("R10 ovr sticky", ovr_err, 1);
        pulse_clr();
        check("R10 cleared", {ovr_err, par_err, frm_err}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule